// File: doc/BRIEF.md
# Dual-Source GPIO Port Resolver

This block models a sixteen-pin general-purpose I/O port that sits behind a simple register bus. Software programs a 32-bit configuration word in which every pin owns two adjacent bits, one selecting output drive and one enabling a weak pull-up, and a 16-bit output word carrying the values the processor wants to drive. A second source, standing for an on-chip peripheral that borrows the pins, presents its own direction and data vectors on dedicated inputs.

The block merges the three contributors into one resolved level per pin: a pin takes the processor's value where the processor drives it, the peripheral's value where the peripheral drives it, and the pull-up setting where neither drives. Reading the data register returns these resolved levels and not the stored output word. Each accepted write to the configuration or data register compares the resolved levels before and after the write and emits a one-cycle change event, with both snapshots exported, when they differ. A separate port interrupt-control register exists only to catch software enabling a feature the port lacks: a nonzero write to it raises an error pulse.

Top module: `gpio_port_resolver`

## Requirements
- R1: After reset the configuration, data and interrupt-control registers are all zero, every pin resolves to 0, and chgPulse, errPulse and busRvalid are low.
- R2: Pin n takes its direction (1 = processor drives) from bit 2n of the configuration register and its pull-up enable from bit 2n+1; the configuration register sits at address 0 and reads back exactly as written.
- R3: The resolved level of each pin is (cpuDir & cpuData) | (periphDir & periphData) | (~(cpuDir | periphDir) & pullUp), evaluated bitwise.
- R4: A read of address 1 returns the resolved pin levels in bits 15:0 with bits 31:16 zero; every read delivers busRdata with busRvalid high in the cycle after busRd.
- R5: In the cycle after an accepted write to address 0 or address 1, chgPulse is high for exactly that cycle if and only if the resolved levels differ, and chgBefore/chgAfter then hold the levels before and after the write.
- R6: The peripheral direction and data inputs are registered every cycle, so pinLevel follows them one cycle later, and a level change caused only by them never raises chgPulse.
- R7: Access size is coded 0 = byte, 1 = 16-bit word, 2 = 32-bit long word; address 0 accepts only long-word writes and addresses 1 and 2 accept only word writes; a write of any other size leaves every register unchanged and raises no event.
- R8: A word write of a nonzero value to the interrupt-control register at address 2 raises errPulse for one cycle in the next cycle; a zero write does not; the written value reads back from address 2.
- R9: Address 3 is unmapped: writes to it change nothing and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write request |
| busRd | input | 1 | Read request |
| busAddr | input | 2 | Register address (0 config, 1 data, 2 interrupt control) |
| busSize | input | 2 | Access size: 0 byte, 1 word, 2 long word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after busRd |
| periphDir | input | 16 | Peripheral drive enable per pin |
| periphData | input | 16 | Peripheral output value per pin |
| pinLevel | output | 16 | Resolved pin levels |
| chgPulse | output | 1 | One-cycle pulse: a write changed the resolved levels |
| chgBefore | output | 16 | Resolved levels before the last changing write |
| chgAfter | output | 16 | Resolved levels after the last changing write |
| errPulse | output | 1 | One-cycle pulse: nonzero write to interrupt control |

## Verification
The bound checker watches, on every cycle, that a change event only follows an accepted configuration or data write and always carries two differing snapshots, that an error pulse only follows a nonzero word write to interrupt control, that read data arrives exactly one cycle after a request, and that data and unmapped reads keep their upper or whole word at zero. Whether the resolved value itself is right, that the bit-pair field split is honoured, that a write which leaves the levels alone stays silent, that wrong-size writes leave the registers untouched and that peripheral-only changes pass through without an event can only be shown by the bench, which predicts every level from its own model of the resolution rule across random and directed patterns.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INTC = 2'd2;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_WORD = 2'd1;
  localparam logic [1:0] SIZE_LONG = 2'd2;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic wrCfg;
    logic wrData;
    logic wrIntc;
    logic rdCfg;
    logic rdData;
    logic rdIntc;
    logic rdAny;
  } strobe_t;

endpackage

// File: rtl/gpio_res_decode.sv
module gpio_res_decode
  import gpio_res_pkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output strobe_t           strb
);

  logic isCfg, isData, isIntc, sizeLong, sizeWord;

  always_comb begin
    isCfg    = (busAddr == ADDR_CFG);
    isData   = (busAddr == ADDR_DATA);
    isIntc   = (busAddr == ADDR_INTC);
    sizeLong = (busSize == SIZE_LONG);
    sizeWord = (busSize == SIZE_WORD);

    strb        = '0;
    strb.wrCfg  = busWr && isCfg  && sizeLong;
    strb.wrData = busWr && isData && sizeWord;
    strb.wrIntc = busWr && isIntc && sizeWord;
    strb.rdCfg  = busRd && isCfg;
    strb.rdData = busRd && isData;
    strb.rdIntc = busRd && isIntc;
    strb.rdAny  = busRd;
  end

endmodule

// File: rtl/gpio_line_resolver.sv
module gpio_line_resolver #(
  parameter int NUM_PINS = 16
) (
  input  logic [2*NUM_PINS-1:0] cfgWord,
  input  logic [NUM_PINS-1:0]   cpuData,
  input  logic [NUM_PINS-1:0]   perDir,
  input  logic [NUM_PINS-1:0]   perData,
  output logic [NUM_PINS-1:0]   level
);

  logic [NUM_PINS-1:0] cpuDir;
  logic [NUM_PINS-1:0] pullUp;

  // Each pin owns an adjacent bit pair: even = drive, odd = pull-up
  for (genvar g = 0; g < NUM_PINS; g++) begin : gFields
    assign cpuDir[g] = cfgWord[2*g];
    assign pullUp[g] = cfgWord[2*g+1];
  end

  assign level = (cpuDir & cpuData)
               | (perDir & perData)
               | (~(cpuDir | perDir) & pullUp);

endmodule

// File: rtl/gpio_res_datapath.sv
module gpio_res_datapath
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int BUS_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [BUS_W-1:0]    busWdata,
  input  logic [NUM_PINS-1:0] periphDir,
  input  logic [NUM_PINS-1:0] periphData,
  output logic [BUS_W-1:0]    busRdata,
  output logic                busRvalid,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic                chgPulse,
  output logic [NUM_PINS-1:0] chgBefore,
  output logic [NUM_PINS-1:0] chgAfter,
  output logic                errPulse
);

  localparam int CFG_W  = 2 * NUM_PINS;
  localparam int WORD_W = BUS_W / 2;

  logic [CFG_W-1:0]    cfgQ, cfgNext;
  logic [NUM_PINS-1:0] dataQ, dataNext;
  logic [WORD_W-1:0]   intcQ;
  logic [NUM_PINS-1:0] perDirQ, perDataQ;
  logic [NUM_PINS-1:0] curLevel, postLevel;
  logic [BUS_W-1:0]    rdMux;
  logic                levelWrite;

  assign cfgNext    = strb.wrCfg  ? busWdata[CFG_W-1:0]    : cfgQ;
  assign dataNext   = strb.wrData ? busWdata[NUM_PINS-1:0] : dataQ;
  assign levelWrite = strb.wrCfg | strb.wrData;

  // Present levels
  gpio_line_resolver #(.NUM_PINS(NUM_PINS)) uCur (
    .cfgWord (cfgQ),
    .cpuData (dataQ),
    .perDir  (perDirQ),
    .perData (perDataQ),
    .level   (curLevel)
  );

  // Levels once the pending write lands, with the peripheral side frozen
  gpio_line_resolver #(.NUM_PINS(NUM_PINS)) uPost (
    .cfgWord (cfgNext),
    .cpuData (dataNext),
    .perDir  (perDirQ),
    .perData (perDataQ),
    .level   (postLevel)
  );

  assign pinLevel = curLevel;

  always_comb begin
    rdMux = '0;
    if (strb.rdCfg)  rdMux = BUS_W'(cfgQ);
    if (strb.rdData) rdMux = BUS_W'(curLevel);
    if (strb.rdIntc) rdMux = BUS_W'(intcQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      dataQ     <= '0;
      intcQ     <= '0;
      perDirQ   <= '0;
      perDataQ  <= '0;
      chgPulse  <= 1'b0;
      chgBefore <= '0;
      chgAfter  <= '0;
      errPulse  <= 1'b0;
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      cfgQ     <= cfgNext;
      dataQ    <= dataNext;
      perDirQ  <= periphDir;
      perDataQ <= periphData;
      if (strb.wrIntc) intcQ <= busWdata[WORD_W-1:0];
      chgPulse <= levelWrite && (postLevel != curLevel);
      if (levelWrite && (postLevel != curLevel)) begin
        chgBefore <= curLevel;
        chgAfter  <= postLevel;
      end
      errPulse  <= strb.wrIntc && (busWdata[WORD_W-1:0] != '0);
      busRvalid <= strb.rdAny;
      busRdata  <= rdMux;
    end
  end

endmodule

// File: rtl/gpio_port_resolver.sv
module gpio_port_resolver
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int BUS_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [1:0]          busAddr,
  input  logic [1:0]          busSize,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  output logic                busRvalid,
  input  logic [NUM_PINS-1:0] periphDir,
  input  logic [NUM_PINS-1:0] periphData,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic                chgPulse,
  output logic [NUM_PINS-1:0] chgBefore,
  output logic [NUM_PINS-1:0] chgAfter,
  output logic                errPulse
);

  strobe_t strb;

  gpio_res_decode uDecode (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .busSize (busSize),
    .strb    (strb)
  );

  gpio_res_datapath #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .periphDir  (periphDir),
    .periphData (periphData),
    .busRdata   (busRdata),
    .busRvalid  (busRvalid),
    .pinLevel   (pinLevel),
    .chgPulse   (chgPulse),
    .chgBefore  (chgBefore),
    .chgAfter   (chgAfter),
    .errPulse   (errPulse)
  );

endmodule

// File: rtl/gpio_port_resolver_chk.sv
module gpio_port_resolver_chk #(
  parameter int NUM_PINS = 16,
  parameter int BUS_W    = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWr,
  input logic                busRd,
  input logic [1:0]          busAddr,
  input logic [1:0]          busSize,
  input logic [BUS_W-1:0]    busWdata,
  input logic [BUS_W-1:0]    busRdata,
  input logic                busRvalid,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic                chgPulse,
  input logic [NUM_PINS-1:0] chgBefore,
  input logic [NUM_PINS-1:0] chgAfter,
  input logic                errPulse
);

  localparam int HALF = BUS_W / 2;

  // R1: first cycle out of reset shows all pins low
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinLevel == '0 && !chgPulse && !errPulse));

  // R5: an event always carries two differing snapshots
  p_event_differs_r5: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |-> (chgBefore != chgAfter));

  // R6 / R7: an event needs an accepted config or data write one cycle earlier
  p_event_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |-> $past(busWr && ((busAddr == 2'd0 && busSize == 2'd2) ||
                                 (busAddr == 2'd1 && busSize == 2'd1))));

  // R8: error only after a nonzero word write to interrupt control
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(busWr && busAddr == 2'd2 && busSize == 2'd1 &&
                       busWdata[HALF-1:0] != '0));

  // R4: read data is valid exactly one cycle after a request
  p_rvalid_timing_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> busRvalid);

  p_rvalid_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRvalid |-> $past(busRd));

  // R4: upper half of a data-register read is zero
  p_data_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRvalid && $past(busAddr == 2'd1)) |-> (busRdata[BUS_W-1:HALF] == '0));

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRvalid && $past(busAddr == 2'd3)) |-> (busRdata == '0));

endmodule

bind gpio_port_resolver gpio_port_resolver_chk #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W)) chk_i (.*);

// File: tb/gpio_port_resolver_tb_top.sv
module gpio_port_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [15:0] periphDir = '0;
  logic [15:0] periphData = '0;
  logic [15:0] pinLevel;
  logic        chgPulse;
  logic [15:0] chgBefore;
  logic [15:0] chgAfter;
  logic        errPulse;

  int nChecks = 0;
  int nFails  = 0;

  // Bench model of register state
  logic [31:0] mCfg  = '0;
  logic [15:0] mData = '0;
  logic [15:0] mIntc = '0;
  logic [15:0] mPdir = '0;
  logic [15:0] mPdat = '0;

  always #10 clk = ~clk;

  gpio_port_resolver dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .periphDir(periphDir), .periphData(periphData),
    .pinLevel(pinLevel), .chgPulse(chgPulse), .chgBefore(chgBefore),
    .chgAfter(chgAfter), .errPulse(errPulse)
  );

  function automatic logic [15:0] resolveM(logic [31:0] c, logic [15:0] d,
                                           logic [15:0] pd, logic [15:0] pv);
    logic [15:0] dir, pu;
    for (int i = 0; i < 16; i++) begin
      dir[i] = c[2*i];
      pu[i]  = c[2*i+1];
    end
    return (dir & d) | (pd & pv) | (~(dir | pd) & pu);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [1:0] sz,
                          input logic [31:0] v);
    logic [15:0] pre, post;
    logic [31:0] nc;
    logic [15:0] nd;
    bit hit, expErr;
    pre = resolveM(mCfg, mData, mPdir, mPdat);
    nc = mCfg; nd = mData; hit = 0;
    if (a == 2'd0 && sz == 2'd2) begin nc = v; hit = 1; end
    if (a == 2'd1 && sz == 2'd1) begin nd = v[15:0]; hit = 1; end
    post = resolveM(nc, nd, mPdir, mPdat);
    expErr = (a == 2'd2 && sz == 2'd1 && v[15:0] != 0);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busSize = sz; busWdata = v;
    @(negedge clk);
    busWr = 1'b0;
    chk(chgPulse == (hit && pre != post), "R5 chgPulse", 32'(chgPulse),
        32'(hit && pre != post));
    if (hit && pre != post) begin
      chk(chgBefore == pre, "R5 chgBefore", 32'(chgBefore), 32'(pre));
      chk(chgAfter == post, "R5 chgAfter", 32'(chgAfter), 32'(post));
    end
    chk(errPulse == expErr, "R8 errPulse", 32'(errPulse), 32'(expErr));
    chk(pinLevel == post, "R3 pinLevel after write", 32'(pinLevel), 32'(post));
    mCfg = nc; mData = nd;
    if (a == 2'd2 && sz == 2'd1) mIntc = v[15:0];
    @(negedge clk);
    chk(!chgPulse && !errPulse, "R5 single-cycle pulse",
        32'({chgPulse, errPulse}), 32'd0);
  endtask

  task automatic busRead(input logic [1:0] a, input logic [1:0] sz, input string tag);
    logic [31:0] exp;
    case (a)
      2'd0:    exp = mCfg;
      2'd1:    exp = 32'(resolveM(mCfg, mData, mPdir, mPdat));
      2'd2:    exp = 32'(mIntc);
      default: exp = '0;
    endcase
    @(negedge clk);
    busRd = 1'b1; busAddr = a; busSize = sz;
    @(negedge clk);
    busRd = 1'b0;
    chk(busRvalid, {tag, " R4 rvalid"}, 32'(busRvalid), 32'd1);
    chk(busRdata == exp, tag, busRdata, exp);
  endtask

  task automatic setPeriph(input logic [15:0] pd, input logic [15:0] pv);
    logic [15:0] exp;
    @(negedge clk);
    periphDir = pd; periphData = pv;
    mPdir = pd; mPdat = pv;
    exp = resolveM(mCfg, mData, mPdir, mPdat);
    @(negedge clk);
    chk(pinLevel == exp, "R6 periph level", 32'(pinLevel), 32'(exp));
    chk(!chgPulse, "R6 no event from periph", 32'(chgPulse), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pinLevel == 0, "R1 pinLevel", 32'(pinLevel), 0);
    chk(!chgPulse && !errPulse && !busRvalid, "R1 pulses", 0, 0);
    busRead(2'd0, 2'd2, "R1 cfg reset");
    busRead(2'd1, 2'd1, "R1 data reset");
    busRead(2'd2, 2'd1, "R1 intc reset");

    // R2: pull-ups only on odd bits -> pins float high
    busWrite(2'd0, 2'd2, 32'hAAAA_AAAA);
    busRead(2'd1, 2'd1, "R2 pullup-only");
    // R2: drive pin 0 and pin 15, data low
    busWrite(2'd0, 2'd2, 32'h4000_0001);
    busRead(2'd0, 2'd2, "R2 cfg readback");
    busWrite(2'd1, 2'd1, 32'h0000_8001);
    busRead(2'd1, 2'd1, "R4 resolved read");
    // R5: data write on undriven pins leaves levels alone -> no event
    busWrite(2'd1, 2'd1, 32'h0000_7FFE | 32'h8001);
    // R6: peripheral drives low pins
    setPeriph(16'h00F0, 16'h0050);
    busRead(2'd1, 2'd1, "R3 mixed sources");
    // R7: wrong-size writes ignored
    busWrite(2'd0, 2'd1, 32'h5555_5555);
    busWrite(2'd1, 2'd2, 32'h0000_0000);
    busWrite(2'd1, 2'd0, 32'h0000_0000);
    busRead(2'd0, 2'd2, "R7 cfg unchanged");
    busRead(2'd1, 2'd1, "R7 data unchanged");
    // R8
    busWrite(2'd2, 2'd1, 32'h0000_0010);
    busRead(2'd2, 2'd1, "R8 intc readback");
    busWrite(2'd2, 2'd1, 32'h0000_0000);
    busWrite(2'd2, 2'd2, 32'h0000_0001);
    // R9
    busWrite(2'd3, 2'd2, 32'hFFFF_FFFF);
    busRead(2'd3, 2'd2, "R9 unmapped read");
    busRead(2'd0, 2'd2, "R9 cfg unchanged");

    for (int it = 0; it < 300; it++) begin
      case ($urandom % 6)
        0: busWrite(2'd0, 2'd2, $urandom);
        1: busWrite(2'd1, 2'd1, {16'h0, 16'($urandom)});
        2: setPeriph(16'($urandom), 16'($urandom));
        3: busRead(2'd1, 2'd1, "R3 random read");
        4: busWrite(2'($urandom), 2'($urandom), $urandom);
        default: busRead(2'd0, 2'd2, "R2 random cfg read");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule